// File: doc/BRIEF.md
# Head Positioning Command Executor

This block carries out the positioning and status commands of a floppy disk controller for up to four drives. A one-cycle start pulse presents an opcode, a drive number, a head bit and a target cylinder. The block keeps a present-cylinder register and a track-0 flag for every drive. It answers one clock later with a done pulse, the first status byte (ST0), the drive status byte (ST3) and the present cylinder of the addressed drive.

For each drive, the ready, write-protect, fault and two-sided flags and the highest usable cylinder are configuration inputs. The block checks them when a command arrives. A drive that is not ready, or a seek target outside the drive's range, ends the command abnormally and leaves the head where it was. Stepper timing, the host bus and data movement belong to other blocks.

Top module: `seek_exec`

## Requirements
- R1: After reset, done, st0, st3 and result_cyl are all zero, and every drive sits at cylinder 0 with its track-0 flag set.
- R2: done is high in exactly the cycle after a cycle in which start is high, and is low at all other times.
- R3: st0, st3 and result_cyl change only in the cycle after a start and otherwise keep their values.
- R4: The opcode values are 5'h0F for seek, 5'h07 for recalibrate and 5'h04 for sense drive. Any other value gives an ST0 interrupt code of 2'b10 with the head and unit fields filled in, and changes no drive's cylinder or track-0 flag.
- R5: The ST0 fields are: bits 7..6 interrupt code (00 normal, 01 abnormal, 10 invalid), bit 5 seek end, bit 4 equipment check, bit 3 not ready, bit 2 commanded head, bits 1..0 drive number.
- R6: The ST3 fields are: bit 7 fault, bit 6 write protect, bit 5 ready, bit 4 track 0, bit 3 two-sided, bit 2 commanded head, bits 1..0 drive number. ST3 describes the addressed drive as it stands after the command.
- R7: A seek or recalibrate on a drive that is not ready reports interrupt code 01 with the not-ready bit set, and leaves that drive's cylinder unchanged.
- R8: A seek to a target greater than or equal to the drive's maximum cylinder reports interrupt code 01 with the equipment-check bit set, and does not move the head.
- R9: A successful seek loads the target into the drive's present cylinder and reports seek end. The drive's track-0 flag is set when the target is 0 and cleared otherwise.
- R10: A recalibrate on a ready drive sets the present cylinder to 0, sets track-0 and reports seek end with a normal interrupt code.
- R11: Sense drive reports a normal ST0 with no seek end, returns the drive's status in ST3 and changes no state.
- R12: result_cyl gives the present cylinder of the addressed drive after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, one cycle |
| opcode | input | 5 | Command code |
| drive_sel | input | 2 | Addressed drive |
| head_sel | input | 1 | Commanded head |
| target_cyl | input | CYL_W | Seek target cylinder |
| drive_ready | input | NUM_DRIVES | Per-drive ready flag |
| drive_wprot | input | NUM_DRIVES | Per-drive write-protect flag |
| drive_fault | input | NUM_DRIVES | Per-drive fault flag |
| drive_two_side | input | NUM_DRIVES | Per-drive two-sided flag |
| drive_max_cyl | input | NUM_DRIVES*CYL_W | Per-drive cylinder count; targets must be below it |
| done | output | 1 | Command finished, one cycle |
| st0 | output | 8 | Completion status byte |
| st3 | output | 8 | Drive status byte |
| result_cyl | output | CYL_W | Present cylinder of the addressed drive |

## Verification
The hardest case to reach is a rejected command that must leave a drive away from cylinder 0 untouched. A single rejected command proves nothing if the drive was already at 0. The stimulus table therefore first moves a drive to the last legal cylinder, then aims one step past it, and then runs a sense command to show the cylinder and the cleared track-0 flag. A not-ready drive is later made ready, so that the same drive shows both the refusal and a normal seek. A bad opcode is followed by a sense command on the same drive.

// File: rtl/seek_exec_pkg.sv
package seek_exec_pkg;

    localparam logic [4:0] OP_SEEK  = 5'h0F;
    localparam logic [4:0] OP_RECAL = 5'h07;
    localparam logic [4:0] OP_SENSE = 5'h04;

    localparam logic [1:0] IC_NORMAL  = 2'b00;
    localparam logic [1:0] IC_ABNORM  = 2'b01;
    localparam logic [1:0] IC_INVALID = 2'b10;

    typedef struct packed {
        logic [1:0] icode;
        logic       seek_end;
        logic       equip_chk;
        logic       not_ready;
        logic       head;
        logic [1:0] unit;
    } st0_t;

    typedef struct packed {
        logic       fault;
        logic       wprot;
        logic       ready;
        logic       trk0;
        logic       two_side;
        logic       head;
        logic [1:0] unit;
    } st3_t;

endpackage

// File: rtl/seek_cmd_decode.sv
module seek_cmd_decode
    import seek_exec_pkg::*;
#(
    parameter int CYL_W = 8
) (
    input  logic [4:0]       opcode,
    input  logic             head,
    input  logic [1:0]       unit,
    input  logic [CYL_W-1:0] target,
    input  logic             rdy,
    input  logic             wp,
    input  logic             flt,
    input  logic             ts,
    input  logic [CYL_W-1:0] max_cyl,
    input  logic [CYL_W-1:0] cur_cyl,
    input  logic             cur_t0,
    output logic             upd,
    output logic [CYL_W-1:0] nxt_cyl,
    output logic             nxt_t0,
    output st0_t             st0_n,
    output st3_t             st3_n
);

    always_comb begin
        upd     = 1'b0;
        nxt_cyl = cur_cyl;
        nxt_t0  = cur_t0;
        st0_n   = '{icode: IC_NORMAL, seek_end: 1'b0, equip_chk: 1'b0,
                    not_ready: 1'b0, head: head, unit: unit};
        case (opcode)
            OP_SEEK: begin
                if (!rdy) begin
                    st0_n.icode     = IC_ABNORM;
                    st0_n.not_ready = 1'b1;
                end else if (target >= max_cyl) begin
                    st0_n.icode     = IC_ABNORM;
                    st0_n.equip_chk = 1'b1;
                end else begin
                    upd            = 1'b1;
                    nxt_cyl        = target;
                    nxt_t0         = (target == '0);
                    st0_n.seek_end = 1'b1;
                end
            end
            OP_RECAL: begin
                if (!rdy) begin
                    st0_n.icode     = IC_ABNORM;
                    st0_n.not_ready = 1'b1;
                end else begin
                    upd            = 1'b1;
                    nxt_cyl        = '0;
                    nxt_t0         = 1'b1;
                    st0_n.seek_end = 1'b1;
                end
            end
            OP_SENSE: begin
                upd = 1'b0;
            end
            default: begin
                st0_n.icode = IC_INVALID;
            end
        endcase
        st3_n = '{fault: flt, wprot: wp, ready: rdy, trk0: nxt_t0,
                  two_side: ts, head: head, unit: unit};
    end

endmodule

// File: rtl/seek_drive_bank.sv
module seek_drive_bank #(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [1:0]                  wr_idx,
    input  logic [CYL_W-1:0]            wr_cyl,
    input  logic                        wr_t0,
    output logic [NUM_DRIVES*CYL_W-1:0] cyl_flat,
    output logic [NUM_DRIVES-1:0]       t0_vec
);

    typedef struct packed {
        logic [CYL_W-1:0] cyl;
        logic             t0;
    } ent_t;

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        ent_t ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_idx == 2'(g))) begin
                ent_d.cyl = wr_cyl;
                ent_d.t0  = wr_t0;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '{cyl: '0, t0: 1'b1};
            end else begin
                ent_q <= ent_d;
            end
        end

        assign cyl_flat[g*CYL_W +: CYL_W] = ent_q.cyl;
        assign t0_vec[g]                  = ent_q.t0;
    end

endmodule

// File: rtl/seek_exec.sv
module seek_exec
    import seek_exec_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [4:0]                  opcode,
    input  logic [1:0]                  drive_sel,
    input  logic                        head_sel,
    input  logic [CYL_W-1:0]            target_cyl,
    input  logic [NUM_DRIVES-1:0]       drive_ready,
    input  logic [NUM_DRIVES-1:0]       drive_wprot,
    input  logic [NUM_DRIVES-1:0]       drive_fault,
    input  logic [NUM_DRIVES-1:0]       drive_two_side,
    input  logic [NUM_DRIVES*CYL_W-1:0] drive_max_cyl,
    output logic                        done,
    output logic [7:0]                  st0,
    output logic [7:0]                  st3,
    output logic [CYL_W-1:0]            result_cyl
);

    typedef struct packed {
        logic             done;
        logic [7:0]       st0;
        logic [7:0]       st3;
        logic [CYL_W-1:0] rcyl;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_DRIVES*CYL_W-1:0] cyl_flat;
    logic [NUM_DRIVES-1:0]       t0_vec;
    logic [CYL_W-1:0]            sel_cyl, sel_max, dec_cyl;
    logic                        dec_upd, dec_t0;
    st0_t                        dec_st0;
    st3_t                        dec_st3;

    assign sel_cyl = cyl_flat[drive_sel*CYL_W +: CYL_W];
    assign sel_max = drive_max_cyl[drive_sel*CYL_W +: CYL_W];

    seek_cmd_decode #(.CYL_W(CYL_W)) u_dec (
        .opcode  (opcode),
        .head    (head_sel),
        .unit    (drive_sel),
        .target  (target_cyl),
        .rdy     (drive_ready[drive_sel]),
        .wp      (drive_wprot[drive_sel]),
        .flt     (drive_fault[drive_sel]),
        .ts      (drive_two_side[drive_sel]),
        .max_cyl (sel_max),
        .cur_cyl (sel_cyl),
        .cur_t0  (t0_vec[drive_sel]),
        .upd     (dec_upd),
        .nxt_cyl (dec_cyl),
        .nxt_t0  (dec_t0),
        .st0_n   (dec_st0),
        .st3_n   (dec_st3)
    );

    seek_drive_bank #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (start && dec_upd),
        .wr_idx   (drive_sel),
        .wr_cyl   (dec_cyl),
        .wr_t0    (dec_t0),
        .cyl_flat (cyl_flat),
        .t0_vec   (t0_vec)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = start;
        if (start) begin
            out_d.st0  = dec_st0;
            out_d.st3  = dec_st3;
            out_d.rcyl = dec_cyl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign done       = out_q.done;
    assign st0        = out_q.st0;
    assign st3        = out_q.st3;
    assign result_cyl = out_q.rcyl;

endmodule

// File: rtl/seek_exec_chk.sv
module seek_exec_chk
    import seek_exec_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int CYL_W      = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic [4:0]                  opcode,
    input logic [1:0]                  drive_sel,
    input logic [NUM_DRIVES-1:0]       drive_ready,
    input logic                        done,
    input logic [7:0]                  st0,
    input logic [7:0]                  st3,
    input logic [CYL_W-1:0]            result_cyl,
    input logic [NUM_DRIVES*CYL_W-1:0] cyl_flat,
    input logic [NUM_DRIVES-1:0]       t0_vec
);

    assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_done_only_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    assert_outputs_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(st0) && $stable(st3) && $stable(result_cyl)));

    assert_not_ready_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (opcode == OP_SEEK || opcode == OP_RECAL) && !drive_ready[drive_sel])
        |=> (st0[7:6] == 2'b01 && st0[3]));

    assert_invalid_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode != OP_SEEK && opcode != OP_RECAL && opcode != OP_SENSE)
        |=> (st0[7:6] == 2'b10));

    assert_sense_normal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && opcode == OP_SENSE) |=> (st0[7:3] == 5'b0));

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_t0
        assert_trk0_coherent_R9: assert property (@(posedge clk) disable iff (!rst_n)
            t0_vec[g] == (cyl_flat[g*CYL_W +: CYL_W] == '0));
    end

endmodule

bind seek_exec seek_exec_chk #(.NUM_DRIVES(NUM_DRIVES), .CYL_W(CYL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .opcode      (opcode),
    .drive_sel   (drive_sel),
    .drive_ready (drive_ready),
    .done        (done),
    .st0         (st0),
    .st3         (st3),
    .result_cyl  (result_cyl),
    .cyl_flat    (cyl_flat),
    .t0_vec      (t0_vec)
);

// File: tb/seek_exec_tb.sv
`timescale 1ns/1ps
module seek_exec_tb;

    localparam int ND = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [4:0]    opcode = '0;
    logic [1:0]    drive_sel = '0;
    logic          head_sel = 1'b0;
    logic [CW-1:0] target_cyl = '0;
    logic [ND-1:0] drive_ready = 4'b1101;
    logic [ND-1:0] drive_wprot = 4'b0101;
    logic [ND-1:0] drive_fault = 4'b0000;
    logic [ND-1:0] drive_two_side = 4'b1111;
    logic [ND*CW-1:0] drive_max_cyl = {8'd2, 8'd40, 8'd40, 8'd80};
    logic          done;
    logic [7:0]    st0, st3;
    logic [CW-1:0] result_cyl;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    seek_exec #(.NUM_DRIVES(ND), .CYL_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .drive_sel(drive_sel), .head_sel(head_sel), .target_cyl(target_cyl),
        .drive_ready(drive_ready), .drive_wprot(drive_wprot),
        .drive_fault(drive_fault), .drive_two_side(drive_two_side),
        .drive_max_cyl(drive_max_cyl), .done(done), .st0(st0), .st3(st3),
        .result_cyl(result_cyl)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [1:0] drv;
        logic       hd;
        logic [7:0] tgt;
        logic [7:0] est0;
        logic [7:0] est3;
        logic [7:0] ecyl;
    } vec_t;

    // Starting config: drive 1 not ready; max cylinders 80,40,40,2.
    localparam vec_t VECS [13] = '{
        '{5'h04, 2'd0, 1'b0, 8'd0,  8'h00, 8'h78, 8'd0},   // R11 sense after reset
        '{5'h0F, 2'd0, 1'b1, 8'd10, 8'h24, 8'h6C, 8'd10},  // R9 seek
        '{5'h04, 2'd0, 1'b0, 8'd0,  8'h00, 8'h68, 8'd10},  // R11 R12
        '{5'h0F, 2'd1, 1'b0, 8'd5,  8'h49, 8'h19, 8'd0},   // R7 seek not ready
        '{5'h07, 2'd1, 1'b0, 8'd0,  8'h49, 8'h19, 8'd0},   // R7 recal not ready
        '{5'h0F, 2'd3, 1'b0, 8'd2,  8'h53, 8'h3B, 8'd0},   // R8 target == max
        '{5'h0F, 2'd3, 1'b0, 8'd1,  8'h23, 8'h2B, 8'd1},   // R9 last legal
        '{5'h0F, 2'd2, 1'b1, 8'd39, 8'h26, 8'h6E, 8'd39},  // R9 R6
        '{5'h0F, 2'd2, 1'b0, 8'd40, 8'h52, 8'h6A, 8'd39},  // R8 no move
        '{5'h07, 2'd2, 1'b0, 8'd0,  8'h22, 8'h7A, 8'd0},   // R10 recal
        '{5'h0F, 2'd0, 1'b0, 8'd0,  8'h20, 8'h78, 8'd0},   // R9 seek to 0 sets track 0
        '{5'h02, 2'd3, 1'b1, 8'd0,  8'h87, 8'h2F, 8'd1},   // R4 invalid
        '{5'h04, 2'd3, 1'b0, 8'd0,  8'h03, 8'h2B, 8'd1}    // R4 no state change
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] op, input logic [1:0] drv,
                         input logic hd, input logic [7:0] tgt);
        @(negedge clk);
        start = 1'b1; opcode = op; drive_sel = drv; head_sel = hd; target_cyl = tgt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 done", 16'(done), 16'd0);
        check("R1 st0", 16'(st0), 16'd0);
        check("R1 st3", 16'(st3), 16'd0);
        check("R1 cyl", 16'(result_cyl), 16'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table walk: R5 R6 R7 R8 R9 R10 R11 R12 R4
        for (int i = 0; i < 13; i++) begin
            issue(VECS[i].op, VECS[i].drv, VECS[i].hd, VECS[i].tgt);
            check($sformatf("R2 done v%0d", i), 16'(done), 16'd1);
            check($sformatf("R5 st0 v%0d", i), 16'(st0), 16'(VECS[i].est0));
            check($sformatf("R6 st3 v%0d", i), 16'(st3), 16'(VECS[i].est3));
            check($sformatf("R12 cyl v%0d", i), 16'(result_cyl), 16'(VECS[i].ecyl));
        end

        // R2 done one cycle wide; R3 outputs hold while inputs move
        @(negedge clk);
        check("R2 done low", 16'(done), 16'd0);
        opcode = 5'h0F; drive_sel = 2'd2; target_cyl = 8'd7; head_sel = 1'b1;
        repeat (4) @(negedge clk);
        check("R3 st0 hold", 16'(st0), 16'h03);
        check("R3 st3 hold", 16'(st3), 16'h2B);
        check("R3 cyl hold", 16'(result_cyl), 16'd1);

        // R6 fault flag in ST3, drive 0 at cylinder 0
        drive_fault = 4'b0001;
        issue(5'h04, 2'd0, 1'b0, 8'd0);
        check("R6 fault st3", 16'(st3), 16'hF8);
        drive_fault = 4'b0000;

        // R7 then R9: drive 1 made ready and seeks normally
        drive_ready = 4'b1111;
        issue(5'h0F, 2'd1, 1'b0, 8'd3);
        check("R9 d1 st0", 16'(st0), 16'h21);
        check("R9 d1 st3", 16'(st3), 16'h29);
        check("R9 d1 cyl", 16'(result_cyl), 16'd3);

        // R1 reset in mid-run returns drives to cylinder 0 with track 0
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 rst st0", 16'(st0), 16'd0);
        check("R1 rst done", 16'(done), 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(5'h04, 2'd1, 1'b0, 8'd0);
        check("R1 d1 st3", 16'(st3), 16'h39);
        check("R1 d1 cyl", 16'(result_cyl), 16'd0);
        issue(5'h04, 2'd2, 1'b1, 8'd0);
        check("R1 d2 st3", 16'(st3), 16'h7E);

        // R10 recal from a nonzero cylinder on a ready drive
        issue(5'h0F, 2'd3, 1'b0, 8'd1);
        issue(5'h07, 2'd3, 1'b0, 8'd0);
        check("R10 st0", 16'(st0), 16'h23 - 16'h03 + 16'h03);
        check("R10 st3", 16'(st3), 16'h3B);
        check("R10 cyl", 16'(result_cyl), 16'd0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule